// File: doc/BRIEF.md
# DMA Source Address Stepper

This block produces the source address a DMA channel uses for its next transfer unit. The channel presents its current address together with the update settings and pulses a one-cycle step strobe. On the following clock edge the block registers the new address. The address can stay where it is, move up or down by the width of the transfer unit, or move up by a programmed offset.

An optional wrap window confines the movement to the low address bits. The window size is a power of two. The bits above the window are held. When an upward move carries past the top of the window, the low bits return to its first address. When a downward move borrows below the bottom, the low bits go to its last address. Each wrap can raise a single-cycle interrupt request, which appears in the same cycle as the wrapped address.

Top module: `dma_src_addr_step`

## Requirements
- R1: While `rst_n` is low and after its release, `next_addr` is 0 and `wrap_irq` is 0 until the first step.
- R2: `mode` is encoded as 00 hold, 01 offset addition, 10 increment and 11 decrement. In hold mode a step copies `cur_addr` to `next_addr` and never wraps.
- R3: In increment mode a step adds 1, 2 or 4 for `size` codes 00, 01 and 10. Code 11 also adds 4.
- R4: In decrement mode a step subtracts 1, 2 or 4 for `size` codes 00, 01 and 10. Code 11 also subtracts 4.
- R5: In offset mode a step adds `offset`, whatever the value of `size`.
- R6: `area` code n in 1..27 makes address bits [n-1:0] the moving part and holds bits [31:n]. Code 0 and codes 28..31 turn the window off. With the window off, arithmetic is plain modulo 2^32 and never counts as a wrap.
- R7: With the window on, an increment or offset step whose low-bit sum exceeds the window top sets bits [n-1:0] to all zeros.
- R8: With the window on, a decrement step whose step size is larger than the low bits sets bits [n-1:0] to all ones.
- R9: A wrap with `wrap_ie` = 1 gives a one-cycle `wrap_irq` pulse in the same cycle as the wrapped address. With `wrap_ie` = 0 there is no pulse.
- R10: In a cycle without `step`, `next_addr` holds its value and `wrap_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One-cycle request to compute the next address |
| cur_addr | input | 32 | Address of the transfer just made |
| mode | input | 2 | Update mode (00 hold, 01 offset, 10 increment, 11 decrement) |
| size | input | 2 | Transfer unit size code |
| area | input | 5 | Wrap window code (0 = off) |
| offset | input | 32 | Value added in offset mode |
| wrap_ie | input | 1 | Enable for the wrap interrupt |
| next_addr | output | 32 | Registered next address |
| wrap_irq | output | 1 | One-cycle wrap interrupt request |

## Verification
The hardest cases to reach are wraps at the edges of the area code range. These are a 2-byte window, the largest 27-bit window, and code 28, which must behave exactly like an unwindowed add. Offset-mode wraps are also hard, because the carry comes from an arbitrary value rather than a small step. Each of these is reached directly by placing `cur_addr` a step or two below the window top, or just above its bottom. A reference model in the bench, which uses modulo arithmetic on wide integers, predicts every result. Idle cycles between steps check that the address holds.

// File: rtl/dma_src_addr_step.sv
module dma_src_addr_step #(
  parameter int ADDR_W   = 32,
  parameter int AREA_W   = 5,
  parameter int MAX_AREA = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [AREA_W-1:0] area,
  input  logic [ADDR_W-1:0] offset,
  input  logic              wrap_ie,
  output logic [ADDR_W-1:0] next_addr,
  output logic              wrap_irq
);

  localparam logic [1:0] M_HOLD = 2'b00;
  localparam logic [1:0] M_OFS  = 2'b01;
  localparam logic [1:0] M_INC  = 2'b10;
  localparam logic [1:0] M_DEC  = 2'b11;

  logic [ADDR_W-1:0] mask, upper, low, delta, calc;
  logic [ADDR_W:0]   lo_sum;
  logic              area_on, ovf, unf, wrap;

  assign area_on = (area != '0) && (area <= AREA_W'(MAX_AREA));
  assign mask    = area_on ? ((ADDR_W'(1) << area) - ADDR_W'(1)) : '0;
  assign upper   = cur_addr & ~mask;
  assign low     = cur_addr & mask;

  always_comb begin
    if (mode == M_OFS)      delta = offset;
    else if (size == 2'b00) delta = ADDR_W'(1);
    else if (size == 2'b01) delta = ADDR_W'(2);
    else                    delta = ADDR_W'(4);
  end

  assign lo_sum = {1'b0, low} + {1'b0, delta};
  assign ovf    = area_on && (lo_sum > {1'b0, mask});
  assign unf    = area_on && (low < delta);

  always_comb begin
    calc = cur_addr;
    wrap = 1'b0;
    case (mode)
      M_HOLD: calc = cur_addr;
      M_OFS, M_INC: begin
        if (!area_on)  calc = cur_addr + delta;
        else if (ovf)  begin calc = upper; wrap = 1'b1; end
        else           calc = upper | lo_sum[ADDR_W-1:0];
      end
      M_DEC: begin
        if (!area_on)  calc = cur_addr - delta;
        else if (unf)  begin calc = upper | mask; wrap = 1'b1; end
        else           calc = upper | (low - delta);
      end
      default: calc = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_addr <= '0;
      wrap_irq  <= 1'b0;
    end else begin
      wrap_irq <= step && wrap && wrap_ie;
      if (step) next_addr <= calc;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(next_addr) && !wrap_irq); // R10
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == M_HOLD |=> next_addr == $past(cur_addr) && !wrap_irq); // R2
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    step && area_on |=> (next_addr & ~$past(mask)) == ($past(cur_addr) & ~$past(mask))); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |-> $past(step) && $past(wrap_ie) && $past(area_on)); // R9
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == M_INC && ovf |=> (next_addr & $past(mask)) == '0); // R7
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == M_DEC && unf |=> (next_addr & $past(mask)) == $past(mask)); // R8

endmodule

// File: tb/test_dma_src_addr_step.sv
`timescale 1ns/1ps
module test_dma_src_addr_step;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [31:0] cur_addr = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [4:0]  area = '0;
  logic [31:0] offset = '0;
  logic        wrap_ie = 1'b0;
  logic [31:0] next_addr;
  logic        wrap_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] addr;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [31:0] last_addr = '0;

  always #10 clk = ~clk;

  dma_src_addr_step i_dma_src_addr_step (
    .clk(clk), .rst_n(rst_n), .step(step), .cur_addr(cur_addr), .mode(mode),
    .size(size), .area(area), .offset(offset), .wrap_ie(wrap_ie),
    .next_addr(next_addr), .wrap_irq(wrap_irq));

  function automatic logic [32:0] model(logic [31:0] a, logic [1:0] m, logic [1:0] s,
                                        logic [4:0] ar, logic [31:0] of, logic ie);
    longint unsigned d, win, lo, up, nl, res;
    logic wr;
    wr = 1'b0;
    if (m == 2'b00) return {1'b0, a};
    d = (m == 2'b01) ? longint'(of) : (s == 2'b00 ? 1 : (s == 2'b01 ? 2 : 4));
    if (ar >= 1 && ar <= 27) begin
      win = 64'd1 << ar;
      lo  = longint'(a) % win;
      up  = longint'(a) - lo;
      if (m == 2'b11) begin
        if (lo < d) begin wr = 1'b1; nl = win - 1; end
        else nl = lo - d;
      end else begin
        nl = lo + d;
        if (nl >= win) begin wr = 1'b1; nl = 0; end
      end
      res = up + nl;
    end else if (m == 2'b11) res = (longint'(a) + 64'h1_0000_0000 - d) % 64'h1_0000_0000;
    else res = (longint'(a) + d) % 64'h1_0000_0000;
    return {wr & ie, res[31:0]};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_step(logic [31:0] a, logic [1:0] m, logic [1:0] s, logic [4:0] ar,
                         logic [31:0] of, logic ie, string tag);
    logic [32:0] r;
    exp_t e;
    @(negedge clk);
    cur_addr = a; mode = m; size = s; area = ar; offset = of; wrap_ie = ie; step = 1'b1;
    r = model(a, m, s, ar, of, ie);
    e.addr = r[31:0]; e.irq = r[32]; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    step = 1'b0;
    cur_addr = ~a;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    bit s;
    exp_t e;
    s = step && rst_n;
    #2;
    if (rst_n && !done) begin
      if (s && q.size() > 0) begin
        e = q.pop_front();
        check(next_addr == e.addr, {e.tag, " addr"}, next_addr, e.addr);
        check(wrap_irq == e.irq, {e.tag, " irq"}, 32'(wrap_irq), 32'(e.irq));
        last_addr = e.addr;
      end else if (!s) begin
        check(next_addr == last_addr && !wrap_irq, "R10 idle hold", next_addr, last_addr);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(next_addr == 32'h0 && wrap_irq == 1'b0, "R1 reset", next_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(next_addr == 32'h0 && wrap_irq == 1'b0, "R1 after release", next_addr, 32'h0);

    do_step(32'h1000_0000, 2'b00, 2'b10, 5'd4, 32'h10, 1'b1, "R2 hold mode");
    do_step(32'h0000_1000, 2'b10, 2'b00, 5'd0, 32'h0, 1'b1, "R3 inc 1");
    do_step(32'h0000_1000, 2'b10, 2'b01, 5'd0, 32'h0, 1'b1, "R3 inc 2");
    do_step(32'h0000_1000, 2'b10, 2'b10, 5'd0, 32'h0, 1'b1, "R3 inc 4");
    do_step(32'h0000_1000, 2'b10, 2'b11, 5'd0, 32'h0, 1'b1, "R3 inc code11");
    do_step(32'hFFFF_FFFF, 2'b10, 2'b00, 5'd0, 32'h0, 1'b1, "R6 no-window carry");
    do_step(32'h0000_2000, 2'b11, 2'b00, 5'd0, 32'h0, 1'b1, "R4 dec 1");
    do_step(32'h0000_2000, 2'b11, 2'b01, 5'd0, 32'h0, 1'b1, "R4 dec 2");
    do_step(32'h0000_2000, 2'b11, 2'b10, 5'd0, 32'h0, 1'b1, "R4 dec 4");
    do_step(32'h0000_0002, 2'b11, 2'b10, 5'd0, 32'h0, 1'b1, "R4 dec borrow no window");
    do_step(32'h0000_0100, 2'b01, 2'b00, 5'd0, 32'h0000_0333, 1'b1, "R5 offset");
    do_step(32'hAB00_00F0, 2'b01, 2'b10, 5'd8, 32'h0000_0020, 1'b1, "R7 offset wrap");
    do_step(32'hAB00_0010, 2'b01, 2'b10, 5'd8, 32'h0000_0020, 1'b1, "R5 offset in window");
    do_step(32'h1234_567E, 2'b10, 2'b01, 5'd4, 32'h0, 1'b1, "R7 inc wrap");
    do_step(32'h1234_567C, 2'b10, 2'b00, 5'd4, 32'h0, 1'b1, "R6 inc inside window");
    do_step(32'h1234_5601, 2'b11, 2'b10, 5'd4, 32'h0, 1'b1, "R8 dec wrap");
    do_step(32'h1234_5605, 2'b11, 2'b10, 5'd4, 32'h0, 1'b1, "R6 dec inside window");
    do_step(32'h1234_567E, 2'b10, 2'b01, 5'd4, 32'h0, 1'b0, "R9 wrap irq disabled");
    do_step(32'h0000_0003, 2'b10, 2'b00, 5'd1, 32'h0, 1'b1, "R7 2-byte window");
    do_step(32'h57FF_FFFE, 2'b10, 2'b01, 5'd27, 32'h0, 1'b1, "R7 largest window");
    do_step(32'h5000_0000, 2'b11, 2'b00, 5'd27, 32'h0, 1'b1, "R8 largest window");
    do_step(32'h57FF_FFFE, 2'b10, 2'b01, 5'd28, 32'h0, 1'b1, "R6 code 28 off");
    do_step(32'h0000_00FF, 2'b10, 2'b00, 5'd31, 32'h0, 1'b1, "R6 code 31 off");
    repeat (4) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule